// File: doc/BRIEF.md
# PCIe Root-Port INTx Event Collector

This block gathers legacy INTx assert and deassert messages seen by a PCIe root port and presents them to software through a small 32-bit register window. Each incoming event carries a two-bit lane number and a level (1 = assert, 0 = deassert). Events are stored in a circular queue. Software reads the oldest entry through two read-word registers and removes it by writing either of them.

A pending-cause register records that INTx traffic has arrived. Software clears its bits by writing ones to them, but the INTx cause comes straight back while the queue still holds entries. A mask register chooses which causes reach the single level-sensitive interrupt line. A control/status register holds a bridge-enable bit, which also drives an output pin. The same register shows a queue-occupancy flag and a sticky overflow flag for events dropped while the queue was full. A read-only PHY status register reports the link-up input.

Register reads are combinational from the address. Writes take effect on the rising clock edge when `reg_wr` is high.

Top module: `rp_intx_collector`

## Requirements
- R1: After reset, every mapped register reads 0, apart from PHY bit 11, which follows the link input. `irq_o` and `bridge_en_o` are 0.
- R2: An accepted event becomes visible at offset 0x158 as word 1 = bit 31 set, level at bit 29 and lane at bits 28:27. Offset 0x15C reads 0. Reading either word does not remove the entry.
- R3: Entries come out in arrival order. A write of any value to 0x158 or to 0x15C removes exactly one entry.
- R4: With the queue empty, both read words return 0, and a write to either of them changes nothing.
- R5: With DEPTH slots, the queue holds DEPTH-1 entries. An event that arrives while it is full is dropped and sets the sticky overflow bit 19 at 0x148. Writing 1 to bit 19 clears it.
- R6: Pending-cause register 0x138 bit 16 is set by every accepted event. Writing 1 to that bit clears it, but only when the queue is empty; otherwise it stays 1. Bit 17 reads 0.
- R7: Register 0x13C is a 32-bit read/write mask. `irq_o` is 1 exactly when some bit is set in both 0x138 and 0x13C.
- R8: Bit 0 of 0x148 is read/write and drives `bridge_en_o`. Bit 18 of 0x148 reads 1 exactly when the queue holds at least one entry.
- R9: Bit 11 of 0x144 reads the value of `link_up_i`. All other bits of 0x144 read 0.
- R10: Unmapped offsets read 0. Writes to them change no register and no queue state.
- R11: When a clear of 0x138 bit 16 and an accepted event fall in the same cycle, bit 16 ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One-cycle INTx event strobe |
| ev_lane | input | 2 | Lane number of the event |
| ev_level | input | 1 | 1 = assert, 0 = deassert |
| link_up_i | input | 1 | Link-up status |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt output |
| bridge_en_o | output | 1 | Bridge enable |

## Verification
Wrong pointer state shows up at the read word on the next read: a repeated, skipped or reordered entry, or a non-zero word on an empty queue. Queue occupancy is also visible at once through bit 18 at 0x148. A wrong fullness decision appears as an extra or missing entry about fifteen pops later, and as a wrong overflow flag on the very next read of 0x148. A stale INTx cause or a bad mask reaches `irq_o` in the cycle after the triggering write or event, so the bench compares `irq_o` after every operation.

// File: rtl/rpi_pkg.sv
package rpi_pkg;
  localparam logic [11:0] OFS_CAUSE = 12'h138;
  localparam logic [11:0] OFS_MASK  = 12'h13C;
  localparam logic [11:0] OFS_PHY   = 12'h144;
  localparam logic [11:0] OFS_CTRL  = 12'h148;
  localparam logic [11:0] OFS_WORD1 = 12'h158;
  localparam logic [11:0] OFS_WORD2 = 12'h15C;

  localparam int B_INTX   = 16;
  localparam int B_MSI    = 17;
  localparam int B_LINK   = 11;
  localparam int B_BRIDGE = 0;
  localparam int B_NEMPTY = 18;
  localparam int B_OVF    = 19;
  localparam int SH_LANE  = 27;
  localparam int SH_LEVEL = 29;
  localparam int SH_VALID = 31;
  localparam int LANE_W   = 2;

  typedef struct packed {
    logic [LANE_W-1:0] lane;
    logic              level;
  } intx_ev_t;

  function automatic logic [31:0] pack_word1(intx_ev_t ev);
    logic [31:0] w;
    w = '0;
    w[SH_VALID] = 1'b1;
    w[SH_LEVEL] = ev.level;
    w[SH_LANE +: LANE_W] = ev.lane;
    return w;
  endfunction

  function automatic logic [31:0] one_bit(int pos, logic v);
    logic [31:0] w;
    w = '0;
    w[pos] = v;
    return w;
  endfunction
endpackage

// File: rtl/rpi_event_fifo.sv
module rpi_event_fifo
  import rpi_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  intx_ev_t         push_ev,
  input  logic             pop,
  output intx_ev_t         head_ev,
  output logic             nonempty,
  output logic             push_ok,
  output logic             push_drop,
  output logic [PTR_W-1:0] rd_ptr
);
  intx_ev_t         slots [DEPTH];
  logic [PTR_W-1:0] rp_q, wp_q;
  logic             full;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty  = (rp_q != wp_q);
  assign full      = (step(wp_q) == rp_q);
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign head_ev   = nonempty ? slots[rp_q] : '0;
  assign rd_ptr    = rp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_q <= '0;
      wp_q <= '0;
    end else begin
      if (push_ok) wp_q <= step(wp_q);
      if (pop && nonempty) rp_q <= step(rp_q);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slots[wp_q] <= push_ev;
  end
endmodule

// File: rtl/rpi_irq_ctrl.sv
module rpi_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cause_wr,
  input  logic        cause_clr_intx,
  input  logic        mask_wr,
  input  logic [31:0] mask_wdata,
  input  logic        enq_ok,
  input  logic        fifo_nonempty,
  output logic        intx_q,
  output logic [31:0] mask_q,
  output logic        irq_o
);
  import rpi_pkg::*;
  logic intx_d;
  logic refresh;

  assign refresh = cause_wr || mask_wr || enq_ok;

  always_comb begin
    intx_d = intx_q;
    if (cause_wr && cause_clr_intx) intx_d = 1'b0;
    if (refresh && (fifo_nonempty || enq_ok)) intx_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intx_q <= 1'b0;
      mask_q <= '0;
    end else begin
      intx_q <= intx_d;
      if (mask_wr) mask_q <= mask_wdata;
    end
  end

  assign irq_o = |(one_bit(B_INTX, intx_q) & mask_q);
endmodule

// File: rtl/rpi_ctrl_status.sv
module rpi_ctrl_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_bridge,
  input  logic wr_ovf_clr,
  input  logic ev_drop,
  output logic bridge_q,
  output logic ovf_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bridge_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (ctrl_wr) bridge_q <= wr_bridge;
      if (ev_drop) ovf_q <= 1'b1;
      else if (ctrl_wr && wr_ovf_clr) ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rp_intx_collector.sv
module rp_intx_collector
  import rpi_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic [1:0]  ev_lane,
  input  logic        ev_level,
  input  logic        link_up_i,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o,
  output logic        bridge_en_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  intx_ev_t         in_ev, head_ev;
  logic             fifo_nonempty, enq_ok, ev_drop;
  logic [PTR_W-1:0] rd_ptr;
  logic             cause_wr, mask_wr, ctrl_wr, pop_req;
  logic             intx_q, ovf_q;
  logic [31:0]      mask_q;

  assign in_ev    = '{lane: ev_lane, level: ev_level};
  assign cause_wr = reg_wr && (reg_addr == OFS_CAUSE);
  assign mask_wr  = reg_wr && (reg_addr == OFS_MASK);
  assign ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
  assign pop_req  = reg_wr && ((reg_addr == OFS_WORD1) || (reg_addr == OFS_WORD2));

  rpi_event_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_valid),
    .push_ev   (in_ev),
    .pop       (pop_req),
    .head_ev   (head_ev),
    .nonempty  (fifo_nonempty),
    .push_ok   (enq_ok),
    .push_drop (ev_drop),
    .rd_ptr    (rd_ptr)
  );

  rpi_irq_ctrl i_irq (
    .clk            (clk),
    .rst_n          (rst_n),
    .cause_wr       (cause_wr),
    .cause_clr_intx (reg_wdata[B_INTX]),
    .mask_wr        (mask_wr),
    .mask_wdata     (reg_wdata),
    .enq_ok         (enq_ok),
    .fifo_nonempty  (fifo_nonempty),
    .intx_q         (intx_q),
    .mask_q         (mask_q),
    .irq_o          (irq_o)
  );

  rpi_ctrl_status i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .wr_bridge  (reg_wdata[B_BRIDGE]),
    .wr_ovf_clr (reg_wdata[B_OVF]),
    .ev_drop    (ev_drop),
    .bridge_q   (bridge_en_o),
    .ovf_q      (ovf_q)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_CAUSE: reg_rdata = one_bit(B_INTX, intx_q) | one_bit(B_MSI, 1'b0);
      OFS_MASK:  reg_rdata = mask_q;
      OFS_PHY:   reg_rdata = one_bit(B_LINK, link_up_i);
      OFS_CTRL:  reg_rdata = one_bit(B_BRIDGE, bridge_en_o) | one_bit(B_NEMPTY, fifo_nonempty)
                           | one_bit(B_OVF, ovf_q);
      OFS_WORD1: reg_rdata = fifo_nonempty ? pack_word1(head_ev) : '0;
      OFS_WORD2: reg_rdata = '0;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rpi_checker.sv
module rpi_checker #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_drop,
  input logic             enq_ok,
  input logic             ovf_q,
  input logic             fifo_nonempty,
  input logic             intx_q,
  input logic             pop_req,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             ctrl_wr,
  input logic [31:0]      reg_wdata,
  input logic             bridge_en_o
);
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_drop |=> ovf_q);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(ctrl_wr && reg_wdata[19])) |=> ovf_q);
  // R6
  intx_forced_chk: assert property (@(posedge clk) disable iff (!rst_n) fifo_nonempty |-> intx_q);
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !fifo_nonempty) |=> $stable(rd_ptr));
  // R2
  enq_visible_chk: assert property (@(posedge clk) disable iff (!rst_n) enq_ok |=> fifo_nonempty);
  // R8
  bridge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_wr |=> $stable(bridge_en_o));
endmodule

bind rp_intx_collector rpi_checker #(.PTR_W(PTR_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_drop       (ev_drop),
  .enq_ok        (enq_ok),
  .ovf_q         (ovf_q),
  .fifo_nonempty (fifo_nonempty),
  .intx_q        (intx_q),
  .pop_req       (pop_req),
  .rd_ptr        (rd_ptr),
  .ctrl_wr       (ctrl_wr),
  .reg_wdata     (reg_wdata),
  .bridge_en_o   (bridge_en_o)
);

// File: tb/test_rp_intx_collector.sv
module test_rp_intx_collector;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [11:0] A_CAUSE = 12'h138, A_MASK = 12'h13C, A_PHY = 12'h144,
                          A_CTRL = 12'h148, A_W1 = 12'h158, A_W2 = 12'h15C;

  logic clk = 0, rst_n = 0, ev_valid = 0, ev_level = 0, link_up_i = 1, reg_wr = 0;
  logic [1:0] ev_lane = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_o, bridge_en_o;

  int checks = 0, errors = 0;
  logic [2:0] mq [DEPTH];
  int mhead = 0, mcnt = 0;
  logic m_intx = 0, m_ovf = 0, m_bridge = 0;
  logic [31:0] m_mask = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rp_intx_collector #(.DEPTH(DEPTH)) i_rp_intx_collector (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_lane(ev_lane), .ev_level(ev_level),
    .link_up_i(link_up_i), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .bridge_en_o(bridge_en_o));

  function automatic logic [31:0] exp_word(logic [2:0] e);
    return 32'h8000_0000 | (32'(e[0]) << 29) | (32'(e[2:1]) << 27);
  endfunction
  function automatic logic [31:0] exp_ctrl();
    return (32'(m_ovf) << 19) | (32'(mcnt > 0) << 18) | 32'(m_bridge);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic m_event(logic [1:0] lane, logic lvl);
    if (mcnt == DEPTH - 1) m_ovf = 1;
    else begin
      mq[(mhead + mcnt) % DEPTH] = {lane, lvl};
      mcnt++;
      m_intx = 1;
    end
  endtask

  task automatic m_write(logic [11:0] a, logic [31:0] d);
    case (a)
      A_CAUSE: begin if (d[16]) m_intx = 0; if (mcnt > 0) m_intx = 1; end
      A_MASK:  m_mask = d;
      A_CTRL:  begin m_bridge = d[0]; if (d[19]) m_ovf = 0; end
      A_W1, A_W2: if (mcnt > 0) begin mhead = (mhead + 1) % DEPTH; mcnt--; end
      default: ;
    endcase
  endtask

  task automatic cycle(logic wr, logic [11:0] a, logic [31:0] d, logic ev, logic [1:0] lane, logic lvl);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    ev_valid = ev; ev_lane = lane; ev_level = lvl;
    @(negedge clk);
    reg_wr = 0; ev_valid = 0;
    if (wr) m_write(a, d);
    if (ev) m_event(lane, lvl);
  endtask

  task automatic chk_irq(string tag);
    checks++;
    if (irq_o !== (m_intx & m_mask[16])) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq_o, m_intx & m_mask[16]);
    end
  endtask

  task automatic chk_all(string tag);
    rd(A_W1, mcnt > 0 ? exp_word(mq[mhead]) : 32'h0, {tag, " R2/R3 word1"});
    rd(A_CAUSE, 32'(m_intx) << 16, {tag, " R6 cause"});
    rd(A_CTRL, exp_ctrl(), {tag, " R8 ctrl"});
    chk_irq({tag, " R7"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_CAUSE, 0, "R1 cause");
    rd(A_MASK, 0, "R1 mask");
    rd(A_CTRL, 0, "R1 ctrl");
    rd(A_W1, 0, "R1 word1");
    check("R1 irq", 32'(irq_o), 0);
    check("R1 bridge", 32'(bridge_en_o), 0);
    // R9 link
    rd(A_PHY, 32'h800, "R9 link up");
    link_up_i = 0;
    rd(A_PHY, 0, "R9 link down");
    link_up_i = 1;
    // R4 pop on empty
    cycle(1, A_W2, 32'hFFFF_FFFF, 0, 0, 0);
    rd(A_W1, 0, "R4 empty word1");
    rd(A_W2, 0, "R4 empty word2");
    // R2 format, non-destructive read
    cycle(0, 0, 0, 1, 2'd3, 1);
    rd(A_W1, 32'hB800_0000, "R2 word1 lane3 assert");
    rd(A_W2, 0, "R2 word2 zero");
    rd(A_W1, 32'hB800_0000, "R2 read keeps entry");
    cycle(0, 0, 0, 1, 2'd1, 0);
    // R3 order; pop via word2 then word1
    cycle(1, A_W2, 0, 0, 0, 0);
    rd(A_W1, 32'h8800_0000, "R3 second entry lane1 deassert");
    // R6 clear ignored while nonempty
    cycle(1, A_CAUSE, 32'h0001_0000, 0, 0, 0);
    rd(A_CAUSE, 32'h0001_0000, "R6 clear while nonempty");
    cycle(1, A_W1, 0, 0, 0, 0);
    rd(A_CTRL, 0, "R8 nonempty clear when empty");
    cycle(1, A_CAUSE, 32'h0001_0000, 0, 0, 0);
    rd(A_CAUSE, 0, "R6 clear when empty");
    // R11 simultaneous clear and event
    cycle(1, A_CAUSE, 32'h0001_0000, 1, 2'd2, 1);
    rd(A_CAUSE, 32'h0001_0000, "R11 enqueue wins");
    // R7 mask
    cycle(1, A_MASK, 32'h0001_0000, 0, 0, 0);
    chk_irq("R7 irq unmasked");
    cycle(1, A_MASK, 32'h0002_0000, 0, 0, 0);
    chk_irq("R7 irq masked");
    rd(A_MASK, 32'h0002_0000, "R7 mask readback");
    // R8 bridge
    cycle(1, A_CTRL, 32'h1, 0, 0, 0);
    check("R8 bridge pin", 32'(bridge_en_o), 1);
    rd(A_CTRL, 32'h0004_0001, "R8 ctrl bridge+nonempty");
    // R10 unmapped
    cycle(1, 12'h140, 32'hFFFF_FFFF, 0, 0, 0);
    rd(12'h140, 0, "R10 unmapped read");
    chk_all("R10 state unchanged");
    // R5 fill to capacity
    while (mcnt < DEPTH - 1) cycle(0, 0, 0, 1, 2'(mcnt), 1'(mcnt));
    rd(A_CTRL, exp_ctrl(), "R5 full no overflow yet");
    cycle(0, 0, 0, 1, 2'd0, 1);
    rd(A_CTRL, 32'h000C_0001, "R5 overflow set");
    cycle(1, A_CTRL, 32'h1, 0, 0, 0);
    rd(A_CTRL, 32'h000C_0001, "R5 overflow sticky");
    for (int i = 0; i < DEPTH - 1; i++) begin
      rd(A_W1, exp_word(mq[mhead]), "R3 drain order");
      cycle(1, A_W1, 0, 0, 0, 0);
    end
    rd(A_W1, 0, "R5 dropped event absent");
    cycle(1, A_CTRL, 32'h0008_0000, 0, 0, 0);
    rd(A_CTRL, 0, "R5 overflow cleared");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2, 3: cycle(0, 0, 0, 1, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
        4, 5: cycle(1, ($urandom_range(0, 1) != 0) ? A_W1 : A_W2, $urandom, 0, 0, 0);
        6: cycle(1, A_CAUSE, $urandom, 0, 0, 0);
        7: cycle(1, A_MASK, $urandom, 0, 0, 0);
        8: cycle(1, A_CTRL, $urandom, 0, 0, 0);
        default: cycle(1, A_CAUSE, 32'h0001_0000, 1, 2'($urandom_range(0, 3)), 1);
      endcase
      chk_all("random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule